// File: doc/BRIEF.md
# Port Link Suspend/Resume Sequencer

This block sequences one port's link through power-management transitions. A controller asks for a suspend or a resume with a single-cycle request. The sequencer checks whether the port may make that move. If it may, it issues writes of the port's link-state field, each with a write strobe, and times the required waits by counting pulses on a millisecond tick input. Either a completion pulse or a rejection pulse reports the outcome. The block also keeps two per-port flags: one that says the port is suspended, and one that says the suspend state has changed.

The suspend path writes U3 and then waits a settle period before it marks the port suspended. The resume path depends on the port's speed. A super-speed port is written straight to U0. Any other port is first written to a resume-signalling state, held there for a fixed number of milliseconds, and only then written to U0. After the U0 write the block emits a one-cycle wake pulse, so that logic outside this block can restart the port's endpoints. While a sequence is running, any new request is refused with a dedicated pulse and the running sequence is not disturbed.

Top module: `port_link_seq`

## Requirements
- R1: While reset is high and in the first cycle after it, every output is 0. This includes link_val, the suspended flag and the change flag.
- R2: In idle, a lone suspend request is accepted when the port is enabled, not in reset, and has link_state_in below 3. The next cycle then shows link_wr=1 with link_val=3 (U3), and seq_busy=1.
- R3: In idle, a lone suspend request that fails any of the R2 conditions gives seq_reject=1 in the next cycle, with link_wr=0.
- R4: After an accepted suspend, seq_done=1 and suspended=1 appear in the cycle after the SUSP_MS-th ms_tick pulse is sampled, and not earlier. Ticks sampled in the same cycle as the request do not count.
- R5: In idle, a lone resume request is rejected (seq_reject=1 next cycle, link_wr=0) in two cases: port_in_reset is 1, or link_state_in equals 3 while port_enabled is 0.
- R6: An accepted resume on a port with is_superspeed=1 gives link_wr=1 with link_val=0 (U0) in the next cycle. The cycle after that shows wake_pulse=1, seq_done=1, suspended=0 and susp_change=1.
- R7: An accepted resume on a port with is_superspeed=0 gives link_wr=1 with link_val=15 in the next cycle. In the cycle after the RESUME_MS-th tick it gives link_wr=1 with link_val=0. The cycle after that shows wake_pulse=1, seq_done=1, suspended=0 and susp_change=1.
- R8: When the sequencer is idle, suspended is 1, link_state_in is 0 and port_powered is 1, the next cycle shows suspended=0 and susp_change=1, with no seq_done and no link write. With port_powered=0 the flag is left unchanged.
- R9: A request that arrives while seq_busy is 1 gives seq_refused=1 in the next cycle. It produces no link write and no rejection, and the running sequence finishes as if the request had not come.
- R10: A chg_clr pulse clears susp_change in the next cycle. If the flag is set in the same cycle as the clear, the set wins.
- R11: Suspend and resume requests that arrive together in idle give seq_reject=1 in the next cycle and no link write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ms_tick | input | 1 | One pulse per millisecond |
| susp_req | input | 1 | Suspend request pulse |
| resume_req | input | 1 | Resume request pulse |
| is_superspeed | input | 1 | The port runs at super speed |
| port_enabled | input | 1 | The port is enabled |
| port_in_reset | input | 1 | A port reset is in progress |
| port_powered | input | 1 | Port power is on |
| link_state_in | input | 4 | Link state currently reported by the port |
| chg_clr | input | 1 | Clears the suspend-change flag |
| link_wr | output | 1 | Strobe for a link-state write |
| link_val | output | 4 | Link-state value written with the strobe |
| seq_busy | output | 1 | A sequence is in progress |
| seq_done | output | 1 | A sequence has completed (pulse) |
| seq_reject | output | 1 | A request failed its preconditions (pulse) |
| seq_refused | output | 1 | A request arrived while busy (pulse) |
| wake_pulse | output | 1 | Endpoints may be restarted (pulse) |
| suspended | output | 1 | The port is marked suspended |
| susp_change | output | 1 | The suspend state has changed |

## Verification
The bench counts the settle and resume holds tick by tick and checks the output one tick before each deadline. A timer that is off by one therefore shows up as a wrong number of cycles before done or before the U0 write. A design that ignored the speed input would write U0 at once on a slower port, or write the resume-signalling value on a super-speed port. The bench also checks three ordering cases. A request during a sequence must be refused and must not restart the sequence or add a write. A clear that lands in the same cycle as a resume must not suppress the change flag. The self-clear of a stale suspended flag must wait until the port is powered.

// File: rtl/link_seq_pkg.sv
package link_seq_pkg;
  localparam int LS_W = 4;
  typedef logic [LS_W-1:0] link_st_t;

  localparam link_st_t LS_U0     = 4'd0;
  localparam link_st_t LS_U3     = 4'd3;
  localparam link_st_t LS_RESUME = 4'd15;

  typedef enum logic [1:0] {
    SQ_IDLE,
    SQ_SUSP_WAIT,
    SQ_RES_HOLD,
    SQ_RES_FIN
  } seq_st_e;
endpackage

// File: rtl/link_ms_timer.sv
module link_ms_timer #(
  parameter int CW = 5
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  input  logic          tick,
  output logic          expire
);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)                  cnt <= '0;
    else if (load)            cnt <= load_val;
    else if (tick && cnt != 0) cnt <= cnt - 1'b1;
  end

  // Expires on the tick that consumes the last remaining count.
  assign expire = tick && !load && (cnt == CW'(1));

  // R4: an idle counter never wraps below zero
  a_r4_timer_floor: assert property (@(posedge clk) disable iff (rst)
    (!load && cnt == 0) |=> (cnt == 0));
endmodule

// File: rtl/link_req_check.sv
module link_req_check
  import link_seq_pkg::*;
(
  input  link_st_t ls,
  input  logic     enabled,
  input  logic     in_reset,
  output logic     susp_ok,
  output logic     resume_ok
);
  always_comb begin
    susp_ok   = enabled && !in_reset && (ls < LS_U3);
    resume_ok = !in_reset && !((ls == LS_U3) && !enabled);
  end
endmodule

// File: rtl/link_flag_keeper.sv
module link_flag_keeper (
  input  logic clk,
  input  logic rst,
  input  logic suspend_done,
  input  logic resume_done,
  input  logic sync_hit,
  input  logic chg_clr,
  output logic suspended,
  output logic susp_chg
);
  always_ff @(posedge clk) begin
    if (rst) begin
      suspended <= 1'b0;
      susp_chg  <= 1'b0;
    end else begin
      if (suspend_done)                 suspended <= 1'b1;
      else if (resume_done || sync_hit) suspended <= 1'b0;

      if (resume_done || sync_hit) susp_chg <= 1'b1;
      else if (chg_clr)            susp_chg <= 1'b0;
    end
  end

  // R6: a finished resume leaves the port unsuspended with the change flag set
  a_r6_resume_flags: assert property (@(posedge clk) disable iff (rst)
    resume_done |=> (susp_chg && !suspended));

  // R10: a set in the same cycle as a clear wins
  a_r10_set_beats_clear: assert property (@(posedge clk) disable iff (rst)
    ((resume_done || sync_hit) && chg_clr) |=> susp_chg);

  // R4: a finished suspend marks the port suspended
  a_r4_suspend_marks: assert property (@(posedge clk) disable iff (rst)
    suspend_done |=> suspended);
endmodule

// File: rtl/port_link_seq.sv
module port_link_seq
  import link_seq_pkg::*;
#(
  parameter int SUSP_MS   = 10,
  parameter int RESUME_MS = 20
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       ms_tick,
  input  logic       susp_req,
  input  logic       resume_req,
  input  logic       is_superspeed,
  input  logic       port_enabled,
  input  logic       port_in_reset,
  input  logic       port_powered,
  input  logic [3:0] link_state_in,
  input  logic       chg_clr,
  output logic       link_wr,
  output logic [3:0] link_val,
  output logic       seq_busy,
  output logic       seq_done,
  output logic       seq_reject,
  output logic       seq_refused,
  output logic       wake_pulse,
  output logic       suspended,
  output logic       susp_change
);
  localparam int MAX_MS = (SUSP_MS > RESUME_MS) ? SUSP_MS : RESUME_MS;
  localparam int CW     = $clog2(MAX_MS + 1);

  seq_st_e       state;
  logic          susp_ok, resume_ok;
  logic          lone_susp, lone_res, any_req;
  logic          tmr_load, tmr_expire;
  logic [CW-1:0] tmr_val;
  logic          suspend_done, resume_done, sync_hit;

  link_req_check u_check (
    .ls        (link_state_in),
    .enabled   (port_enabled),
    .in_reset  (port_in_reset),
    .susp_ok   (susp_ok),
    .resume_ok (resume_ok)
  );

  always_comb begin
    lone_susp    = susp_req && !resume_req;
    lone_res     = resume_req && !susp_req;
    any_req      = susp_req || resume_req;
    tmr_load     = (state == SQ_IDLE) &&
                   ((lone_susp && susp_ok) || (lone_res && resume_ok && !is_superspeed));
    tmr_val      = lone_susp ? CW'(SUSP_MS) : CW'(RESUME_MS);
    suspend_done = (state == SQ_SUSP_WAIT) && tmr_expire;
    resume_done  = (state == SQ_RES_FIN);
    sync_hit     = (state == SQ_IDLE) && suspended &&
                   (link_state_in == LS_U0) && port_powered;
  end

  link_ms_timer #(.CW(CW)) u_timer (
    .clk      (clk),
    .rst      (rst),
    .load     (tmr_load),
    .load_val (tmr_val),
    .tick     (ms_tick),
    .expire   (tmr_expire)
  );

  link_flag_keeper u_flags (
    .clk          (clk),
    .rst          (rst),
    .suspend_done (suspend_done),
    .resume_done  (resume_done),
    .sync_hit     (sync_hit),
    .chg_clr      (chg_clr),
    .suspended    (suspended),
    .susp_chg     (susp_change)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state       <= SQ_IDLE;
      link_wr     <= 1'b0;
      link_val    <= LS_U0;
      seq_done    <= 1'b0;
      seq_reject  <= 1'b0;
      seq_refused <= 1'b0;
      wake_pulse  <= 1'b0;
    end else begin
      link_wr     <= 1'b0;
      seq_done    <= 1'b0;
      seq_reject  <= 1'b0;
      seq_refused <= 1'b0;
      wake_pulse  <= 1'b0;
      if (state != SQ_IDLE && any_req) seq_refused <= 1'b1;
      case (state)
        SQ_IDLE: begin
          if (susp_req && resume_req) begin
            seq_reject <= 1'b1;
          end else if (susp_req) begin
            if (susp_ok) begin
              link_wr  <= 1'b1;
              link_val <= LS_U3;
              state    <= SQ_SUSP_WAIT;
            end else begin
              seq_reject <= 1'b1;
            end
          end else if (resume_req) begin
            if (resume_ok) begin
              link_wr <= 1'b1;
              if (is_superspeed) begin
                link_val <= LS_U0;
                state    <= SQ_RES_FIN;
              end else begin
                link_val <= LS_RESUME;
                state    <= SQ_RES_HOLD;
              end
            end else begin
              seq_reject <= 1'b1;
            end
          end
        end
        SQ_SUSP_WAIT: begin
          if (tmr_expire) begin
            seq_done <= 1'b1;
            state    <= SQ_IDLE;
          end
        end
        SQ_RES_HOLD: begin
          if (tmr_expire) begin
            link_wr  <= 1'b1;
            link_val <= LS_U0;
            state    <= SQ_RES_FIN;
          end
        end
        SQ_RES_FIN: begin
          wake_pulse <= 1'b1;
          seq_done   <= 1'b1;
          state      <= SQ_IDLE;
        end
        default: state <= SQ_IDLE;
      endcase
    end
  end

  assign seq_busy = (state != SQ_IDLE);

  // R3: a suspend on a disabled port is rejected without a write
  a_r3_disabled_no_write: assert property (@(posedge clk) disable iff (rst)
    (state == SQ_IDLE && lone_susp && !port_enabled) |=> (seq_reject && !link_wr));

  // R7: the wake pulse always follows a U0 write
  a_r7_wake_after_u0: assert property (@(posedge clk) disable iff (rst)
    wake_pulse |-> ($past(link_wr) && link_val == LS_U0));

  // R9: requests during a sequence are refused, never rejected
  a_r9_busy_refuse: assert property (@(posedge clk) disable iff (rst)
    (state != SQ_IDLE && any_req) |=> (seq_refused && !seq_reject));

  // R2: a U3 write is always followed by the settle wait
  a_r2_u3_then_wait: assert property (@(posedge clk) disable iff (rst)
    (link_wr && link_val == LS_U3) |-> (state == SQ_SUSP_WAIT));

  // R11: simultaneous requests in idle are rejected
  a_r11_both_reject: assert property (@(posedge clk) disable iff (rst)
    (state == SQ_IDLE && susp_req && resume_req) |=> (seq_reject && !link_wr));
endmodule

// File: tb/port_link_seq_bench.sv
module port_link_seq_bench;
  localparam int CLK_PERIOD = 10;
  localparam int SMS = 10;
  localparam int RMS = 20;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ms_tick = 0, susp_req = 0, resume_req = 0, is_superspeed = 0;
  logic port_enabled = 0, port_in_reset = 0, port_powered = 1, chg_clr = 0;
  logic [3:0] link_state_in = 4'd0;
  logic link_wr, seq_busy, seq_done, seq_reject, seq_refused, wake_pulse;
  logic suspended, susp_change;
  logic [3:0] link_val;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  port_link_seq #(.SUSP_MS(SMS), .RESUME_MS(RMS)) u_port_link_seq (
    .clk(clk), .rst(rst), .ms_tick(ms_tick), .susp_req(susp_req),
    .resume_req(resume_req), .is_superspeed(is_superspeed),
    .port_enabled(port_enabled), .port_in_reset(port_in_reset),
    .port_powered(port_powered), .link_state_in(link_state_in),
    .chg_clr(chg_clr), .link_wr(link_wr), .link_val(link_val),
    .seq_busy(seq_busy), .seq_done(seq_done), .seq_reject(seq_reject),
    .seq_refused(seq_refused), .wake_pulse(wake_pulse),
    .suspended(suspended), .susp_change(susp_change)
  );

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic pulse_susp();
    susp_req = 1'b1; step(); susp_req = 1'b0;
  endtask

  task automatic pulse_res();
    resume_req = 1'b1; step(); resume_req = 1'b0;
  endtask

  task automatic ticks(int n);
    for (int i = 0; i < n; i++) begin
      ms_tick = 1'b1; step(); ms_tick = 1'b0;
    end
  endtask

  task automatic do_suspend();
    port_enabled = 1'b1; link_state_in = 4'd0;
    pulse_susp();
    link_state_in = 4'd3;
    ticks(SMS);
  endtask

  task automatic t_reset();
    chk("R1 link_wr", link_wr, 0);
    chk("R1 link_val", link_val, 0);
    chk("R1 busy", seq_busy, 0);
    chk("R1 suspended", suspended, 0);
    chk("R1 change", susp_change, 0);
    chk("R1 done", seq_done, 0);
  endtask

  task automatic t_suspend_ok();
    port_enabled = 1'b1; link_state_in = 4'd1; ms_tick = 1'b1;
    pulse_susp();
    ms_tick = 1'b0;
    chk("R2 link_wr", link_wr, 1);
    chk("R2 link_val U3", link_val, 3);
    chk("R2 busy", seq_busy, 1);
    link_state_in = 4'd3;
    pulse_res();
    chk("R9 refused", seq_refused, 1);
    chk("R9 no write", link_wr, 0);
    chk("R9 no reject", seq_reject, 0);
    ticks(SMS - 1);
    chk("R4 not yet suspended", suspended, 0);
    chk("R4 not yet done", seq_done, 0);
    ticks(1);
    chk("R4 suspended", suspended, 1);
    chk("R4 done", seq_done, 1);
    chk("R4 idle", seq_busy, 0);
    step();
    chk("R4 done pulse ends", seq_done, 0);
  endtask

  task automatic t_ss_resume();
    is_superspeed = 1'b1; port_enabled = 1'b1; link_state_in = 4'd3;
    pulse_res();
    chk("R6 link_wr", link_wr, 1);
    chk("R6 link_val U0", link_val, 0);
    chk("R6 no wake yet", wake_pulse, 0);
    chg_clr = 1'b1; step(); chg_clr = 1'b0;
    chk("R6 wake", wake_pulse, 1);
    chk("R6 done", seq_done, 1);
    chk("R6 suspended cleared", suspended, 0);
    chk("R10 set beats clear", susp_change, 1);
    link_state_in = 4'd0;
    step();
    chk("R6 wake pulse ends", wake_pulse, 0);
  endtask

  task automatic t_clear_change();
    chg_clr = 1'b1; step(); chg_clr = 1'b0;
    chk("R10 cleared", susp_change, 0);
  endtask

  task automatic t_hs_resume();
    is_superspeed = 1'b0;
    do_suspend();
    chk("R4 suspended again", suspended, 1);
    pulse_res();
    chk("R7 link_wr", link_wr, 1);
    chk("R7 link_val resume", link_val, 15);
    link_state_in = 4'd15;
    ticks(RMS - 1);
    chk("R7 no early U0", link_wr, 0);
    chk("R7 still suspended", suspended, 1);
    ticks(1);
    chk("R7 U0 write", link_wr, 1);
    chk("R7 link_val U0", link_val, 0);
    chk("R7 no wake yet", wake_pulse, 0);
    link_state_in = 4'd0;
    step();
    chk("R7 wake", wake_pulse, 1);
    chk("R7 done", seq_done, 1);
    chk("R7 suspended cleared", suspended, 0);
    chk("R7 change", susp_change, 1);
    chg_clr = 1'b1; step(); chg_clr = 1'b0;
  endtask

  task automatic t_rejects();
    port_enabled = 1'b0; link_state_in = 4'd2;
    pulse_susp();
    chk("R3 disabled reject", seq_reject, 1);
    chk("R3 disabled no write", link_wr, 0);
    port_enabled = 1'b1; link_state_in = 4'd3;
    pulse_susp();
    chk("R3 U3 reject", seq_reject, 1);
    port_in_reset = 1'b1; link_state_in = 4'd0;
    pulse_susp();
    chk("R3 in reset reject", seq_reject, 1);
    pulse_res();
    chk("R5 in reset reject", seq_reject, 1);
    chk("R5 in reset no write", link_wr, 0);
    port_in_reset = 1'b0; port_enabled = 1'b0; link_state_in = 4'd3;
    pulse_res();
    chk("R5 U3 disabled reject", seq_reject, 1);
    chk("R5 U3 disabled no write", link_wr, 0);
    port_enabled = 1'b1; link_state_in = 4'd0;
    susp_req = 1'b1; resume_req = 1'b1; step();
    susp_req = 1'b0; resume_req = 1'b0;
    chk("R11 both reject", seq_reject, 1);
    chk("R11 both no write", link_wr, 0);
    chk("R11 stays idle", seq_busy, 0);
  endtask

  task automatic t_sync();
    do_suspend();
    chk("R8 setup suspended", suspended, 1);
    port_powered = 1'b0; link_state_in = 4'd0;
    step(); step();
    chk("R8 unpowered keeps flag", suspended, 1);
    port_powered = 1'b1;
    step();
    chk("R8 suspended cleared", suspended, 0);
    chk("R8 change set", susp_change, 1);
    chk("R8 no done", seq_done, 0);
    chk("R8 no write", link_wr, 0);
  endtask

  initial begin
    step(); step();
    t_reset();
    rst = 1'b0;
    step();
    t_reset();
    t_suspend_ok();
    t_ss_resume();
    t_clear_change();
    t_hs_resume();
    t_rejects();
    t_sync();
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL R1 watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule